// File: doc/BRIEF.md
# Instruction cache line invalidator

This block carries out the "invalidate one instruction cache line" operation of a processor pipeline. It recognises the 32-bit encoding of the invalidate instruction, decides whether the current privilege level allows it, and works out which line of a direct-mapped instruction cache the address operand names. It then clears that line's tag, valid bit included, through a single-entry write port on an external tag array.

A legal request is taken in only while the block is idle. The write, or the privilege trap that replaces it, appears in the first cycle after acceptance. A completion pulse follows in the second cycle, and the block is then free again. The line length (4 or 8 words) and the total cache size are parameters, so the width of the line index follows from them. Another parameter states whether a memory management unit is present. Only in that case does the instruction become privileged, and issuing it in user mode raises a privileged-instruction exception with a fixed code instead of touching the cache. The second register operand and the cache-enable bit play no part in the operation.

Top module: `icache_line_inval`

## Requirements
- R1: An instruction is recognised only when instr[31:26]=100100, instr[25:21]=00000 and instr[10:0]=00001101000, with instr[20:16] and instr[15:11] free. Any other word presented with issue_valid causes no busy, tag_we, priv_exc or done.
- R2: The rb_val input and the cache_enable input have no effect. The line index, the write and the exception are the same for any value of either.
- R3: With LINE_WORDS=4, tag_index equals (ra_val >> 4) masked to log2(CACHE_BYTES)-4 bits.
- R4: With LINE_WORDS=8, tag_index equals (ra_val >> 5) masked to log2(CACHE_BYTES)-5 bits.
- R5: For a permitted instruction, tag_we is high for exactly one cycle: the first cycle after acceptance. In that cycle tag_wdata is all zeros.
- R6: With MMU_LEVEL >= 1 and user_mode=1, no tag write occurs. priv_exc pulses for one cycle in the first cycle after acceptance, and exc_code reads 5'b00111.
- R7: With MMU_LEVEL=0, the instruction is never trapped and writes the tag in user mode as well.
- R8: exc_code resets to 0 and changes only in a cycle where priv_exc is high.
- R9: done pulses in the second cycle after acceptance. In the cycle after that, busy is low again.
- R10: busy is high from the first cycle after acceptance through the done cycle. A request presented while busy is dropped and never produces a write. After reset, busy, tag_we, priv_exc and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction word is presented this cycle |
| instr | input | 32 | Instruction word (bit 31 is the most significant) |
| ra_val | input | 32 | Address operand naming the cache line |
| rb_val | input | 32 | Second operand, unused |
| user_mode | input | 1 | Processor is in user mode |
| cache_enable | input | 1 | Instruction cache enable status, unused |
| busy | output | 1 | An accepted operation is in progress |
| tag_we | output | 1 | Tag array write enable |
| tag_index | output | log2(CACHE_BYTES)-4 or -5 | Line selected for the write, zero when not writing |
| tag_wdata | output | TAG_W | Data written to the tag array, always zero |
| priv_exc | output | 1 | Privileged-instruction exception pulse |
| exc_code | output | 5 | Exception code, updated only when the exception fires |
| done | output | 1 | Operation complete pulse |

## Verification
Acceptance happens at the clock edge that samples issue_valid. The tag write or trap is therefore due one edge later, the done pulse two edges later, and the idle state three edges later. The bench drives inputs on the falling edge. It then samples at each of the next three falling edges and checks the write-or-trap outputs, the completion outputs and the idle state at exactly those points. For a rejected encoding or a request made while busy, it samples one falling edge after the edge that could have accepted the request. Two instances, one per line length and privilege setting, run the same stimulus, and the expected indices are recomputed from ra_val by shift and mask.

// File: rtl/icinv_pkg.sv
package icinv_pkg;

    localparam logic [5:0]  OPC_MAJOR = 6'b100100;
    localparam logic [4:0]  OPC_RSVD  = 5'b00000;
    localparam logic [10:0] OPC_FUNC  = 11'b00001101000;
    localparam logic [4:0]  EXC_PRIV  = 5'b00111;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic hit;   // word matches the invalidate encoding
        logic trap;  // privileged and issued from user mode
    } dec_t;

    function automatic logic is_inval_word(input logic [31:0] w);
        return (w[31:26] == OPC_MAJOR) && (w[25:21] == OPC_RSVD) && (w[10:0] == OPC_FUNC);
    endfunction

    function automatic int line_shift(input int words);
        return (words == 8) ? 5 : 4;
    endfunction

endpackage

// File: rtl/icinv_decode.sv
module icinv_decode
    import icinv_pkg::*;
#(
    parameter int MMU_LEVEL = 1
) (
    input  logic [31:0] instr,
    input  logic        user_mode,
    output dec_t        dec
);

    logic hit;
    assign hit = is_inval_word(instr);

    generate
        if (MMU_LEVEL >= 1) begin : g_priv
            assign dec.trap = hit && user_mode;
        end else begin : g_nopriv
            logic unused_um;
            assign unused_um = user_mode;
            assign dec.trap  = 1'b0;
        end
    endgenerate

    assign dec.hit = hit;

endmodule

// File: rtl/icinv_index.sv
module icinv_index
    import icinv_pkg::*;
#(
    parameter int LINE_WORDS  = 4,
    parameter int CACHE_BYTES = 1024,
    parameter int IDX_W       = $clog2(CACHE_BYTES) - line_shift(LINE_WORDS)
) (
    input  logic [31:0]      ra,
    output logic [IDX_W-1:0] idx
);

    localparam int SH = line_shift(LINE_WORDS);

    generate
        if (LINE_WORDS == 8) begin : g_line8
            assign idx = ra[5 +: IDX_W];
        end else begin : g_line4
            assign idx = ra[4 +: IDX_W];
        end
    endgenerate

    logic unused_ra;
    assign unused_ra = ^{ra[SH-1:0], ra[31:SH+IDX_W]};

endmodule

// File: rtl/icinv_seq.sv
module icinv_seq
    import icinv_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_valid,
    input  dec_t             dec,
    input  logic [IDX_W-1:0] idx_in,
    output logic             busy,
    output logic             tag_we,
    output logic [IDX_W-1:0] tag_index,
    output logic             priv_exc,
    output logic [4:0]       exc_code,
    output logic             done
);

    seq_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             trap_q;
    logic [4:0]       exc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            trap_q  <= 1'b0;
            exc_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (issue_valid && dec.hit) begin
                        state_q <= ST_EXEC;
                        idx_q   <= idx_in;
                        trap_q  <= dec.trap;
                        if (dec.trap) begin
                            exc_q <= EXC_PRIV;
                        end
                    end
                end
                ST_EXEC: state_q <= ST_DONE;
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        tag_we    = (state_q == ST_EXEC) && !trap_q;
        priv_exc  = (state_q == ST_EXEC) && trap_q;
        tag_index = tag_we ? idx_q : '0;
        done      = (state_q == ST_DONE);
        exc_code  = exc_q;
    end

endmodule

// File: rtl/icache_line_inval.sv
module icache_line_inval
    import icinv_pkg::*;
#(
    parameter int LINE_WORDS  = 4,
    parameter int CACHE_BYTES = 1024,
    parameter int MMU_LEVEL   = 1,
    parameter int TAG_W       = 22,
    localparam int IDX_W      = $clog2(CACHE_BYTES) - line_shift(LINE_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_valid,
    input  logic [31:0]      instr,
    input  logic [31:0]      ra_val,
    input  logic [31:0]      rb_val,
    input  logic             user_mode,
    input  logic             cache_enable,
    output logic             busy,
    output logic             tag_we,
    output logic [IDX_W-1:0] tag_index,
    output logic [TAG_W-1:0] tag_wdata,
    output logic             priv_exc,
    output logic [4:0]       exc_code,
    output logic             done
);

    dec_t             dec;
    logic [IDX_W-1:0] line_idx;

    icinv_decode #(
        .MMU_LEVEL(MMU_LEVEL)
    ) decode_i (
        .instr    (instr),
        .user_mode(user_mode),
        .dec      (dec)
    );

    icinv_index #(
        .LINE_WORDS (LINE_WORDS),
        .CACHE_BYTES(CACHE_BYTES),
        .IDX_W      (IDX_W)
    ) index_i (
        .ra (ra_val),
        .idx(line_idx)
    );

    icinv_seq #(
        .IDX_W(IDX_W)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .issue_valid(issue_valid),
        .dec        (dec),
        .idx_in     (line_idx),
        .busy       (busy),
        .tag_we     (tag_we),
        .tag_index  (tag_index),
        .priv_exc   (priv_exc),
        .exc_code   (exc_code),
        .done       (done)
    );

    // A cleared tag also clears the valid bit.
    assign tag_wdata = '0;

    logic unused_ops;
    assign unused_ops = ^{rb_val, cache_enable};

endmodule

// File: rtl/icinv_chk.sv
module icinv_chk #(
    parameter int MMU_LEVEL = 1
) (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       tag_we,
    input logic       priv_exc,
    input logic [4:0] exc_code,
    input logic       done
);

    // R5
    tag_we_single_chk: assert property (@(posedge clk) disable iff (rst)
        tag_we |=> !tag_we);

    // R5
    we_trap_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(tag_we && priv_exc));

    // R6
    trap_code_chk: assert property (@(posedge clk) disable iff (rst)
        priv_exc |-> (exc_code == 5'b00111));

    // R8
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !priv_exc |-> $stable(exc_code));

    // R9
    done_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (tag_we || priv_exc) |=> done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R10
    busy_span_chk: assert property (@(posedge clk) disable iff (rst)
        (tag_we || priv_exc || done) |-> busy);

    generate
        if (MMU_LEVEL == 0) begin : g_nommu
            // R7
            never_trap_chk: assert property (@(posedge clk) disable iff (rst)
                !priv_exc);
        end
    endgenerate

endmodule

bind icache_line_inval icinv_chk #(.MMU_LEVEL(MMU_LEVEL)) chk_i (.*);

// File: tb/icache_line_inval_tb_top.sv
`timescale 1ns/1ps
module icache_line_inval_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] ra_val = '0;
    logic [31:0] rb_val = '0;
    logic        user_mode = 1'b0;
    logic        cache_enable = 1'b0;

    // instance A: 4-word lines, 256 bytes, MMU present
    logic        a_busy, a_we, a_priv, a_done;
    logic [3:0]  a_idx;
    logic [21:0] a_wd;
    logic [4:0]  a_exc;
    // instance B: 8-word lines, 512 bytes, no MMU
    logic        b_busy, b_we, b_priv, b_done;
    logic [3:0]  b_idx;
    logic [21:0] b_wd;
    logic [4:0]  b_exc;

    int checks = 0;
    int errors = 0;
    int exc_model_a = 0;

    localparam logic [31:0] GOOD = {6'b100100, 5'b00000, 5'd3, 5'd7, 11'b00001101000};

    always #2 clk = ~clk;

    icache_line_inval #(.LINE_WORDS(4), .CACHE_BYTES(256), .MMU_LEVEL(1), .TAG_W(22)) dut_i (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .instr(instr), .ra_val(ra_val),
        .rb_val(rb_val), .user_mode(user_mode), .cache_enable(cache_enable),
        .busy(a_busy), .tag_we(a_we), .tag_index(a_idx), .tag_wdata(a_wd),
        .priv_exc(a_priv), .exc_code(a_exc), .done(a_done));

    icache_line_inval #(.LINE_WORDS(8), .CACHE_BYTES(512), .MMU_LEVEL(0), .TAG_W(22)) dut_b_i (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .instr(instr), .ra_val(ra_val),
        .rb_val(rb_val), .user_mode(user_mode), .cache_enable(cache_enable),
        .busy(b_busy), .tag_we(b_we), .tag_index(b_idx), .tag_wdata(b_wd),
        .priv_exc(b_priv), .exc_code(b_exc), .done(b_done));

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic quiet(input string req);
        chk(req, "A busy", int'(a_busy), 0);
        chk(req, "A tag_we", int'(a_we), 0);
        chk(req, "A priv_exc", int'(a_priv), 0);
        chk(req, "A done", int'(a_done), 0);
        chk(req, "B busy", int'(b_busy), 0);
        chk(req, "B tag_we", int'(b_we), 0);
        chk(req, "B done", int'(b_done), 0);
    endtask

    // Issue one legal instruction and follow it through three falling edges.
    task automatic run_op(input logic [31:0] ra, input logic [31:0] rb,
                          input logic um, input logic ce, input string idx_req);
        @(negedge clk);
        issue_valid = 1'b1; instr = GOOD; ra_val = ra; rb_val = rb;
        user_mode = um; cache_enable = ce;
        @(negedge clk);
        issue_valid = 1'b0;
        rb_val = ~rb; cache_enable = ~ce;
        if (um) exc_model_a = 7;
        // first cycle after acceptance
        chk("R6", "A tag_we", int'(a_we), um ? 0 : 1);
        chk("R6", "A priv_exc", int'(a_priv), int'(um));
        chk(idx_req, "A tag_index", int'(a_idx), um ? 0 : int'((ra >> 4) & 32'hF));
        chk("R5", "A tag_wdata", int'(a_wd), 0);
        chk("R8", "A exc_code", int'(a_exc), exc_model_a);
        chk("R7", "B tag_we", int'(b_we), 1);
        chk("R7", "B priv_exc", int'(b_priv), 0);
        chk("R4", "B tag_index", int'(b_idx), int'((ra >> 5) & 32'hF));
        chk("R8", "B exc_code", int'(b_exc), 0);
        chk("R10", "A busy", int'(a_busy), 1);
        @(negedge clk);
        // second cycle
        chk("R9", "A done", int'(a_done), 1);
        chk("R9", "B done", int'(b_done), 1);
        chk("R5", "A tag_we second", int'(a_we), 0);
        chk("R5", "B tag_we second", int'(b_we), 0);
        chk("R8", "A exc_code hold", int'(a_exc), exc_model_a);
        @(negedge clk);
        quiet("R9");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state R10, R8
        quiet("R10");
        chk("R8", "A exc_code reset", int'(a_exc), 0);

        // sweep over line indices, privilege and unused inputs: R3, R4, R6, R7, R2
        for (int um = 0; um < 2; um++) begin
            for (int ce = 0; ce < 2; ce++) begin
                for (int i = 0; i < 32; i++) begin
                    logic [31:0] ra;
                    ra = 32'hA5A5_0000 ^ (32'(i) << 4) ^ (32'(um) << 11) ^ 32'(ce * 5);
                    run_op(ra, 32'(i * 17 + ce), um[0], ce[0], "R3");
                end
            end
        end

        // R2: same address, differing rb_val and cache_enable
        run_op(32'h0000_00D0, 32'h0, 1'b0, 1'b0, "R2");
        run_op(32'h0000_00D0, 32'hFFFF_FFFF, 1'b0, 1'b1, "R2");

        // R1: each fixed encoding bit flipped is ignored
        for (int b = 0; b < 32; b++) begin
            if (b >= 11 && b <= 20) continue;
            @(negedge clk);
            issue_valid = 1'b1; instr = GOOD ^ (32'h1 << b);
            ra_val = 32'h40; user_mode = 1'b1;
            @(negedge clk);
            issue_valid = 1'b0;
            quiet("R1");
            chk("R1", "A exc_code", int'(a_exc), exc_model_a);
        end

        // R1: register select fields are free
        @(negedge clk);
        issue_valid = 1'b1; instr = GOOD ^ 32'h001F_F800; ra_val = 32'h70; user_mode = 1'b0;
        @(negedge clk);
        issue_valid = 1'b0;
        chk("R1", "A tag_we free fields", int'(a_we), 1);
        chk("R1", "A tag_index free fields", int'(a_idx), 7);
        repeat (2) @(negedge clk);

        // R10: request while busy is dropped
        @(negedge clk);
        issue_valid = 1'b1; instr = GOOD; ra_val = 32'h30; user_mode = 1'b0;
        @(negedge clk);
        chk("R10", "A tag_index first", int'(a_idx), 3);
        ra_val = 32'h50;  // still issuing while in progress
        @(negedge clk);
        issue_valid = 1'b0;
        chk("R10", "A done", int'(a_done), 1);
        chk("R10", "A tag_we during done", int'(a_we), 0);
        @(negedge clk);
        quiet("R10");
        @(negedge clk);
        quiet("R10");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule